// File: doc/BRIEF.md
# SMBus Slave Front End with Strapped Address

This block is the bus-facing half of a serially managed peripheral. It watches the two-wire clock and data lines, oversampled by the system clock through two-flop synchronizers. It recognises start and stop conditions and shifts in the address byte. When the address is its own, it acknowledges by driving an open-drain enable for the data line. After that, each data byte the master writes is passed to a register file on a one-cycle strobe. In a read, each byte is fetched from the register file through a one-cycle request and shifted out most significant bit first.

The seven-bit address has a fixed upper part, `01011`. The two low bits come from a board strap that is already classified as low, open or high. The strap is captured once, at the first start condition after reset, and later strap changes have no effect until the next reset.

The controller is a single state machine. Its states are IDLE (released, waiting for a start), ADDR (shifting the address byte), ADDR_ACK (driving the address acknowledge), WR_DATA (shifting a written byte), WR_ACK (driving the data acknowledge), RD_DATA (shifting a read byte out) and RD_ACK (SDA released, sampling the master's acknowledge). Its transitions are as follows. A start moves any state to ADDR, and a stop moves any state to IDLE. After the eighth address bit, ADDR goes to ADDR_ACK on a match and to IDLE on a mismatch. On the ninth falling clock edge, ADDR_ACK goes to WR_DATA or to RD_DATA, depending on the direction bit. After eight bits, WR_DATA goes to WR_ACK, and on the next falling edge WR_ACK goes back to WR_DATA. After eight bits, RD_DATA goes to RD_ACK. From RD_ACK, a master ACK leads back to RD_DATA at the falling edge, and a NACK leads to IDLE at the rising edge.

Top module: `smb_strap_slave`

## Requirements
- R1: While reset is held and straight after it is released, `sda_oe`, `wr_valid` and `rd_req` are all 0.
- R2: The slave address is `01011` followed by two strap bits. `strap_lvl` is coded 00 = tied low, 01 = open, 10 = tied high, and 11 is treated as open. Low gives bits 00, open gives 10 and high gives 01, so an open strap gives 0x2E. The address byte is sent MSB first and is followed by a direction bit (0 = write, 1 = read).
- R3: On a matching address, `sda_oe` is 1 for the whole high period of the ninth SCL pulse. On a mismatch, `sda_oe` stays 0 and no `wr_valid` or `rd_req` occurs until the next start.
- R4: The strap bits are captured at the first start condition after reset. A strap change after that neither adds the new address nor removes the captured one.
- R5: In a write, every data byte is acknowledged. `wr_valid` pulses for one cycle with `wr_data` holding the byte, MSB received first.
- R6: In a read, each byte is taken from `rd_data` in the cycle `rd_req` is 1 and driven MSB first. SDA is released for the ninth clock.
- R7: A master ACK on the ninth clock fetches the next byte. A master NACK ends the read: no further `rd_req`, and SDA stays released until the next start.
- R8: A stop condition releases SDA and returns the slave to IDLE. A repeated start at any point discards a partly received byte and waits for a new address.
- R9: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| strap_lvl | input | 2 | Classified strap level: 00 low, 01 open, 10 high |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received byte, valid with `wr_valid` |
| rd_req | output | 1 | One-cycle request; `rd_data` is taken in this cycle |
| rd_data | input | 8 | Byte to transmit, supplied by the register file |

## Verification
Write bursts of random length and content check that each byte is reassembled in bit order and strobed exactly once. Random addresses that differ from the captured one check that the comparator never acknowledges a neighbour and stays idle afterwards. Reads with a final NACK, followed by extra clocks, separate a correct end of read from a slave that keeps fetching. The other directed runs cover three things. A stop or repeated start in mid-byte tells abort handling apart from byte completion. A strap change after the first transaction shows that the address is locked. Resets with each strap level check every code of the strap decode.

// File: rtl/smb_strap_pkg.sv
package smb_strap_pkg;
    localparam int SMB_DATA_W = 8;
    localparam int SMB_ADDR_W = SMB_DATA_W - 1;
    localparam int SMB_CNT_W  = $clog2(SMB_DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA, ST_WR_ACK, ST_RD_DATA, ST_RD_ACK
    } smb_state_t;

    // strap code to the two low address bits
    function automatic logic [1:0] strap_to_bits(input logic [1:0] lvl);
        unique case (lvl)
            2'b00:   return 2'b00;   // tied low
            2'b10:   return 2'b01;   // tied high
            default: return 2'b10;   // open (and unused code)
        endcase
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s,
    output logic line_p
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe   <= '1;
            line_p <= 1'b1;
        end else begin
            pipe   <= {pipe[STAGES-2:0], line_i};
            line_p <= pipe[STAGES-1];
        end
    end

    assign line_s = pipe[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    logic [LINES-1:0] raw, cur, prv;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .line_s (cur[g]),
            .line_p (prv[g])
        );
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  = cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] & prv[0];
    assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
    assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/smb_addr_lock.sv
module smb_addr_lock
    import smb_strap_pkg::*;
#(
    parameter logic [SMB_ADDR_W-3:0] FIXED_HI = 5'b01011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_det,
    input  logic [1:0]            strap_lvl,
    output logic [SMB_ADDR_W-1:0] addr_o,
    output logic                  locked_o
);
    logic [1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
            low_q    <= 2'b00;
        end else if (start_det && !locked_o) begin
            locked_o <= 1'b1;
            low_q    <= strap_to_bits(strap_lvl);
        end
    end

    assign addr_o = {FIXED_HI, low_q};
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
    import smb_strap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [SMB_ADDR_W-1:0] addr,
    input  logic [SMB_DATA_W-1:0] rd_data,
    output logic                  sda_oe,
    output logic                  wr_valid,
    output logic [SMB_DATA_W-1:0] wr_data,
    output logic                  rd_req,
    output smb_state_t            state_o
);
    localparam logic [SMB_CNT_W-1:0] FULL = SMB_CNT_W'(SMB_DATA_W);

    smb_state_t            state_q, state_d;
    logic [SMB_DATA_W-1:0] sh, tx;
    logic [SMB_CNT_W-1:0]  cnt;
    logic                  ack_seen;
    logic                  hit;

    assign hit     = (sh[SMB_DATA_W-1:1] == addr);
    assign rd_req  = scl_fall && ((state_q == ST_ADDR_ACK && sh[0]) ||
                                  (state_q == ST_RD_ACK && ack_seen));
    assign wr_data = sh;
    assign state_o = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && cnt == FULL) state_d = hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = sh[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && cnt == FULL) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt == FULL) state_d = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_s)          state_d = ST_IDLE;
                    else if (scl_fall && ack_seen)  state_d = ST_RD_DATA;
                end
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            sh       <= '0;
            tx       <= '0;
            cnt      <= '0;
            ack_seen <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            if (stop_det || start_det) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
            end else begin
                unique case (state_q)
                    ST_IDLE: sda_oe <= 1'b0;
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise && cnt != FULL) begin
                            sh  <= {sh[SMB_DATA_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state_q == ST_WR_DATA) begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                            end else begin
                                sda_oe <= hit;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (sh[0]) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[SMB_DATA_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: if (scl_fall) sda_oe <= 1'b0;
                    ST_RD_DATA: begin
                        if (scl_rise && cnt != FULL) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == FULL) begin
                                sda_oe   <= 1'b0;
                                ack_seen <= 1'b0;
                            end else begin
                                tx     <= tx << 1;
                                sda_oe <= ~tx[SMB_DATA_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            ack_seen <= ~sda_s;
                        end else if (scl_fall && ack_seen) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[SMB_DATA_W-1];
                            cnt    <= '0;
                        end
                    end
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_strap_slave.sv
module smb_strap_slave
    import smb_strap_pkg::*;
#(
    parameter int                    SYNC_STAGES = 2,
    parameter logic [SMB_ADDR_W-3:0] FIXED_HI    = 5'b01011
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [1:0]            strap_lvl,
    output logic                  wr_valid,
    output logic [SMB_DATA_W-1:0] wr_data,
    output logic                  rd_req,
    input  logic [SMB_DATA_W-1:0] rd_data
);
    logic                  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [SMB_ADDR_W-1:0] slave_addr;
    logic                  addr_locked;
    smb_state_t            fsm_state;

    smb_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_addr_lock #(.FIXED_HI(FIXED_HI)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .strap_lvl (strap_lvl),
        .addr_o    (slave_addr),
        .locked_o  (addr_locked)
    );

    smb_slave_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr      (slave_addr),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .state_o   (fsm_state)
    );
endmodule

// File: rtl/smb_strap_slave_chk.sv
module smb_strap_slave_chk
    import smb_strap_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  sda_oe,
    input logic                  wr_valid,
    input logic                  rd_req,
    input logic                  stop_det,
    input logic                  addr_locked,
    input logic [SMB_ADDR_W-1:0] slave_addr,
    input smb_state_t            fsm_state
);
    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);                                            // R9
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_state == ST_IDLE |-> !sda_oe);                                       // R3
    AST_ADDR_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_locked |=> addr_locked && $stable(slave_addr));                     // R4
    AST_WR_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);                                                 // R5
    AST_RD_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);                                                     // R6
    AST_WR_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_req));                                                  // R5
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe && fsm_state == ST_IDLE);                           // R8
endmodule

bind smb_strap_slave smb_strap_slave_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_oe      (sda_oe),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .stop_det    (stop_det),
    .addr_locked (addr_locked),
    .slave_addr  (slave_addr),
    .fsm_state   (fsm_state)
);

// File: tb/smb_strap_slave_tb_top.sv
module smb_strap_slave_tb_top;
    localparam int Q = 8;
    localparam logic [1:0] S_LOW = 2'b00, S_OPEN = 2'b01, S_HIGH = 2'b10, S_BAD = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap = S_HIGH;
    logic       sda_oe, wr_valid, rd_req, sda_bus;
    logic [7:0] wr_data, rd_data;

    int errors = 0, checks = 0, wr_n = 0, rd_n = 0, oe_bad = 0;
    logic [7:0] wr_log [0:63];
    logic oe_prev = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    function automatic logic [7:0] rd_fn(input int n);
        return 8'(n * 59 + 165);
    endfunction
    assign rd_data = rd_fn(rd_n);

    function automatic logic [6:0] exp_addr(input logic [1:0] s);
        logic [1:0] lo;
        lo = (s == S_LOW) ? 2'b00 : (s == S_HIGH) ? 2'b01 : 2'b10;
        return {5'b01011, lo};
    endfunction

    smb_strap_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .strap_lvl(strap), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data)
    );

    always @(posedge clk) begin
        if (wr_valid) begin
            if (wr_n < 64) wr_log[wr_n] <= wr_data;
            wr_n <= wr_n + 1;
        end
        if (rd_req) rd_n <= rd_n + 1;
    end

    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad++;
        oe_prev = sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0; strap = s; scl_m = 1'b1; sda_m = 1'b1;
        hold(5);
        rst_n = 1'b1;
        hold(5);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q); sda_m = 1'b1; hold(Q);
    endtask

    task automatic clock_bit(input logic b, output logic s1, output logic s2);
        sda_m = b; hold(Q);
        scl_m = 1'b1; hold(2); s1 = sda_bus;
        hold(Q - 2); s2 = sda_bus;
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], a1, a2);
        clock_bit(1'b1, a1, a2);
        ack = !a1 && !a2;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, a1, a2);
            b[i] = a2;
        end
        clock_bit(!m_ack, a1, a2);
        sda_m = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic       ack;
        logic [7:0] b, d;
        logic [6:0] a;
        int         base, rbase, n;
        void'($urandom(32'd4711));

        // R1 reset state
        rst_n = 1'b0; hold(3);
        check("R1 oe in reset", sda_oe, 0);
        check("R1 wr_valid in reset", wr_valid, 0);
        rst_n = 1'b1; hold(2);
        check("R1 rd_req after reset", rd_req, 0);
        check("R1 oe after reset", sda_oe, 0);

        // strap high, first transaction locks; random write bursts
        do_reset(S_HIGH);
        for (int t = 0; t < 3; t++) begin
            base = wr_n;
            n = 1 + ($urandom % 4);
            bus_start();
            send_byte({exp_addr(S_HIGH), 1'b0}, ack);
            check("R2 R3 address ack strap high", ack, 1);
            for (int k = 0; k < n; k++) begin
                d = 8'($urandom);
                send_byte(d, ack);
                check("R5 data ack", ack, 1);
                hold(2);
                check("R5 wr_data", wr_log[base + k], d);
            end
            bus_stop();
            check("R5 write count", wr_n - base, n);
            check("R8 oe after stop", sda_oe, 0);
            if (t == 0) strap = S_OPEN;   // changes after lock must not matter
        end

        // R4 lock: open address not taken, high still answered
        bus_start();
        send_byte({exp_addr(S_OPEN), 1'b0}, ack);
        check("R4 new strap address ignored", ack, 0);
        bus_stop();
        bus_start();
        send_byte({exp_addr(S_HIGH), 1'b1}, ack);
        check("R4 locked address kept", ack, 1);
        recv_byte(1'b0, b);
        bus_stop();

        // R3 random mismatching addresses
        for (int t = 0; t < 6; t++) begin
            base = wr_n; rbase = rd_n;
            a = 7'($urandom);
            if (a == exp_addr(S_HIGH)) a = a ^ 7'h01;
            bus_start();
            send_byte({a, t[0]}, ack);
            check("R3 mismatch not acked", ack, 0);
            send_byte(8'($urandom), ack);
            check("R3 stays idle after mismatch", ack, 0);
            bus_stop();
            check("R3 no write strobe", wr_n - base, 0);
            check("R3 no read request", rd_n - rbase, 0);
        end

        // R6/R7 read of four bytes, NACK on the last
        rbase = rd_n;
        bus_start();
        send_byte({exp_addr(S_HIGH), 1'b1}, ack);
        check("R6 read address ack", ack, 1);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k != 3, b);
            check("R6 read byte", b, rd_fn(rbase + k));
        end
        check("R6 requests per byte", rd_n - rbase, 4);
        recv_byte(1'b1, b);
        check("R7 released after NACK", b, 8'hFF);
        check("R7 no request after NACK", rd_n - rbase, 4);
        bus_stop();

        // R8 repeated start mid byte
        base = wr_n; rbase = rd_n;
        bus_start();
        send_byte({exp_addr(S_HIGH), 1'b0}, ack);
        for (int i = 0; i < 4; i++) begin
            logic s1, s2;
            clock_bit(1'($urandom), s1, s2);
        end
        bus_start();
        send_byte({exp_addr(S_HIGH), 1'b1}, ack);
        check("R8 address after repeated start", ack, 1);
        recv_byte(1'b0, b);
        check("R8 read after repeated start", b, rd_fn(rbase));
        bus_stop();
        check("R8 partial byte dropped", wr_n - base, 0);

        // R8 stop mid byte
        base = wr_n;
        bus_start();
        send_byte({exp_addr(S_HIGH), 1'b0}, ack);
        for (int i = 0; i < 3; i++) begin
            logic s1, s2;
            clock_bit(1'b0, s1, s2);
        end
        hold(Q);
        bus_stop();
        scl_m = 1'b0; hold(Q);
        send_byte(8'h5A, ack);
        check("R8 no ack without start", ack, 0);
        bus_stop();
        check("R8 no write after stop", wr_n - base, 0);

        // R2 other strap codes
        do_reset(S_LOW);
        bus_start();
        send_byte({exp_addr(S_LOW), 1'b0}, ack);
        check("R2 strap low address", ack, 1);
        bus_stop();
        bus_start();
        send_byte({exp_addr(S_OPEN), 1'b0}, ack);
        check("R2 open address under low strap", ack, 0);
        bus_stop();
        do_reset(S_OPEN);
        bus_start();
        send_byte({7'h2E, 1'b0}, ack);
        check("R2 open strap address 2E", ack, 1);
        bus_stop();
        do_reset(S_BAD);
        bus_start();
        send_byte({7'h2E, 1'b0}, ack);
        check("R2 code 11 treated as open", ack, 1);
        bus_stop();

        check("R9 oe changed while SCL high", oe_bad, 0);
        done = 1'b1;
        finish_run();
    end
endmodule